// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause-22 management transactions towards one or more Ethernet PHYs. It owns the management clock line and the bidirectional data line. The data line appears as three signals: a driven value, an output enable, and the value seen on the pad. A host starts a transaction with a one-cycle request that carries the direction (read or write), a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. When the frame is over, the block pulses a done strobe. For a read it returns the register value, or an error flag if no PHY drove the turnaround bit low.

Each management clock period has a low half and then a high half. Each half lasts a programmable number of system clocks. The block places every outgoing bit on the data line at the start of a low half, so the bit is stable across the following rising edge. It samples incoming bits at the end of a high half, after a two-flop synchronizer. A read frame checks the turnaround bit. If no PHY answers, the block clocks 32 released cycles so that any confused device can recover, and then reports the error. Both frame types end with a few released trailing clock cycles, and then the clock parks low.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After a synchronous reset: `mdc_o` is 0, `mdio_oe_o` is 0, `busy_o` is 0, `done_o` is 0 and `err_o` is 0.
- R2: Every frame begins with 32 MDC periods during which MDIO is driven (`mdio_oe_o`=1) with the value 1.
- R3: After the preamble, the block drives 14 bits, most significant first, in this order: start `0,1`; opcode `1,0` for a read or `0,1` for a write; the 5-bit PHY address; the 5-bit register address.
- R4: Each MDC half-period lasts max(1, `half_cfg_i`) system clocks, so a value of 0 acts as 1. The value is captured when a request is accepted. `mdio_o` and `mdio_oe_o` change only while MDC is low.
- R5: On a read, MDIO is released from the turnaround slot to the end of the frame. The input is sampled at the end of the high half of each slot. The turnaround sample must be 0. The next 16 slots give the data, most significant bit first. Two released slots follow, for 65 MDC rising edges in total. The input must be stable for 2 system clocks before each sampling point.
- R6: If the turnaround sample is 1, the block gives 32 more released slots, for 79 MDC rising edges in total. It then ends with `err_o`=1 and `rd_data_o`=0.
- R7: On a write, the block drives turnaround `1,0`, then 16 data bits most significant first. One released slot follows, for 65 MDC rising edges in total.
- R8: `busy_o` rises only in the cycle after a request is accepted. It stays high for the whole frame. A request made while busy is ignored: it produces no frame and no done.
- R9: When a frame ends, `done_o` is high for exactly one clock. In that clock MDC is low, MDIO is released and `busy_o` is 0. `err_o` keeps its value until the next frame ends (writes clear it). `rd_data_o` changes only at the end of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start request, one cycle, accepted when not busy |
| req_read_i | input | 1 | 1 = read frame, 0 = write frame |
| req_phy_i | input | 5 | Target PHY address |
| req_reg_i | input | 5 | Target register address |
| req_wdata_i | input | 16 | Write value |
| half_cfg_i | input | 8 | MDC half-period in system clocks (0 treated as 1) |
| mdio_i | input | 1 | MDIO pad input |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO driven value |
| mdio_oe_o | output | 1 | MDIO output enable |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-clock end-of-frame strobe |
| err_o | output | 1 | Last frame was a read with no PHY answer |
| rd_data_o | output | 16 | Data of the last read frame |

## Verification
The assertions assume two things. First, the host raises a request only as a clean one-cycle pulse and holds `half_cfg_i` while it does so. Second, the PHY side changes `mdio_i` only at falling MDC edges, so the synchronized value has settled before the end of each high half. To meet this, the bench PHY model drives its response bits when it sees MDC fall. Every read frame uses a half-period of at least 2 clocks, so the synchronizer lag stays inside the slot. Half-periods of 0 and 1 appear only on write frames, where nothing is sampled.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SEND,
    ST_TURN,
    ST_RDAT,
    ST_TAIL
  } mdio_state_e;

  localparam logic [1:0] START_PAT  = 2'b01;
  localparam logic [1:0] OPC_READ   = 2'b10;
  localparam logic [1:0] OPC_WRITE  = 2'b01;
  localparam logic [1:0] TURN_WRITE = 2'b10;

  localparam int RD_TAIL_SLOTS = 2;
  localparam int WR_TAIL_SLOTS = 1;

endpackage

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half_len,
  output logic              tick
);
  logic [HALF_W-1:0] lim;
  logic [HALF_W-1:0] cnt;

  assign lim  = (half_len == '0) ? HALF_W'(1) : half_len;
  assign tick = run && (cnt == lim - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + HALF_W'(1);
  end

  // R4
  half_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < lim));

  // R4
  half_tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tick) |=> (cnt == '0));
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [DATA_W-1:0] word_o
);
  always_ff @(posedge clk) begin
    if (rst || clr)    word_o <= '0;
    else if (shift_en) word_o <= {word_o[DATA_W-2:0], bit_i};
  end

  // R5
  rx_msb_first_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !clr) |=> (word_o[0] == $past(bit_i)
                           && word_o[DATA_W-1:1] == $past(word_o[DATA_W-2:0])));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int HALF_W    = 8,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int PRE_LEN   = 32,
  parameter int RECOV_LEN = 32,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              req_read_i,
  input  logic [ADDR_W-1:0] req_phy_i,
  input  logic [ADDR_W-1:0] req_reg_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [HALF_W-1:0] half_cfg_i,
  input  logic              mdio_i,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int HDR_W = 4 + 2 * ADDR_W;
  localparam int TX_W  = HDR_W + 2 + DATA_W;
  localparam int MAX_A = (PRE_LEN > RECOV_LEN) ? PRE_LEN : RECOV_LEN;
  localparam int MAX_C = (MAX_A > TX_W) ? MAX_A : TX_W;
  localparam int CNT_W = $clog2(MAX_C + 1);

  mdio_state_e       state;
  logic              phase;
  logic [CNT_W-1:0]  cnt;
  logic [TX_W-1:0]   txsr;
  logic              rd_q;
  logic              err_pend;
  logic [HALF_W-1:0] half_q;
  logic              mdc_q, mdo_q, oe_q, busy_q, done_q, err_q;
  logic [DATA_W-1:0] rd_q_data;

  logic              tick;
  logic              sin;
  logic              slot_end;
  logic              rx_shift;
  logic              accept;
  logic [DATA_W-1:0] rx_word;

  assign accept   = (state == ST_IDLE) && req_i;
  assign slot_end = tick && phase;
  assign rx_shift = slot_end && (state == ST_RDAT);

  mdio_in_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (mdio_i),
    .dout(sin)
  );

  mdio_half_timer #(.HALF_W(HALF_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (busy_q),
    .half_len(half_q),
    .tick    (tick)
  );

  mdio_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept),
    .shift_en(rx_shift),
    .bit_i   (sin),
    .word_o  (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      phase     <= 1'b0;
      cnt       <= '0;
      txsr      <= '0;
      rd_q      <= 1'b0;
      err_pend  <= 1'b0;
      half_q    <= '0;
      mdc_q     <= 1'b0;
      mdo_q     <= 1'b1;
      oe_q      <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      rd_q_data <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state    <= ST_PRE;
        cnt      <= CNT_W'(PRE_LEN - 1);
        phase    <= 1'b0;
        mdc_q    <= 1'b0;
        mdo_q    <= 1'b1;
        oe_q     <= 1'b1;
        busy_q   <= 1'b1;
        rd_q     <= req_read_i;
        err_pend <= 1'b0;
        half_q   <= half_cfg_i;
        txsr     <= {START_PAT, (req_read_i ? OPC_READ : OPC_WRITE),
                     req_phy_i, req_reg_i, TURN_WRITE, req_wdata_i};
      end else if (busy_q && tick) begin
        if (!phase) begin
          mdc_q <= 1'b1;
          phase <= 1'b1;
        end else begin
          mdc_q <= 1'b0;
          phase <= 1'b0;
          case (state)
            ST_PRE: begin
              if (cnt == '0) begin
                state <= ST_SEND;
                cnt   <= rd_q ? CNT_W'(HDR_W - 1) : CNT_W'(TX_W - 1);
                mdo_q <= txsr[TX_W-1];
                txsr  <= {txsr[TX_W-2:0], 1'b0};
              end else begin
                cnt <= cnt - CNT_W'(1);
              end
            end
            ST_SEND: begin
              if (cnt == '0) begin
                oe_q  <= 1'b0;
                mdo_q <= 1'b1;
                if (rd_q) begin
                  state <= ST_TURN;
                end else begin
                  state <= ST_TAIL;
                  cnt   <= CNT_W'(WR_TAIL_SLOTS - 1);
                end
              end else begin
                cnt   <= cnt - CNT_W'(1);
                mdo_q <= txsr[TX_W-1];
                txsr  <= {txsr[TX_W-2:0], 1'b0};
              end
            end
            ST_TURN: begin
              if (sin) begin
                state    <= ST_TAIL;
                cnt      <= CNT_W'(RECOV_LEN - 1);
                err_pend <= 1'b1;
              end else begin
                state <= ST_RDAT;
                cnt   <= CNT_W'(DATA_W - 1);
              end
            end
            ST_RDAT: begin
              if (cnt == '0) begin
                state <= ST_TAIL;
                cnt   <= CNT_W'(RD_TAIL_SLOTS - 1);
              end else begin
                cnt <= cnt - CNT_W'(1);
              end
            end
            ST_TAIL: begin
              if (cnt == '0) begin
                state  <= ST_IDLE;
                busy_q <= 1'b0;
                done_q <= 1'b1;
                err_q  <= err_pend;
                if (rd_q) rd_q_data <= err_pend ? '0 : rx_word;
              end else begin
                cnt <= cnt - CNT_W'(1);
              end
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign mdc_o     = mdc_q;
  assign mdio_o    = mdo_q;
  assign mdio_oe_o = oe_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign rd_data_o = rd_q_data;

  // R2
  pre_drive_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRE) |-> (oe_q && mdo_q));

  // R4
  mdio_change_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdo_q) || !$stable(oe_q)) |-> !mdc_q);

  // R4
  mdc_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdc_q) |-> $past(tick));

  // R5
  read_released_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TURN || state == ST_RDAT) |-> !oe_q);

  // R6
  err_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> done_q);

  // R8
  busy_from_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(req_i));

  // R9
  done_parked_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!mdc_q && !oe_q && !busy_q));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
  localparam int HALF_W = 8;
  localparam logic [4:0] PHY_AD = 5'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_i = 1'b0, req_read_i = 1'b0;
  logic [4:0] req_phy_i = '0, req_reg_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [HALF_W-1:0] half_cfg_i = '0;
  logic mdio_i = 1'b1;
  logic mdc_o, mdio_o, mdio_oe_o, busy_o, done_o, err_o;
  logic [15:0] rd_data_o;

  always #4 clk = ~clk;

  mdio_mgmt_master u0 (
    .clk(clk), .rst(rst), .req_i(req_i), .req_read_i(req_read_i),
    .req_phy_i(req_phy_i), .req_reg_i(req_reg_i), .req_wdata_i(req_wdata_i),
    .half_cfg_i(half_cfg_i), .mdio_i(mdio_i), .mdc_o(mdc_o), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .rd_data_o(rd_data_o)
  );

  int vectors = 0;
  int misses  = 0;
  int mon_frames = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  function automatic logic [15:0] phy_word(logic [4:0] rg);
    return {rg, 3'b110, ~rg, 3'b001};
  endfunction

  // frame recorder: value on MDIO at each MDC rising edge
  logic rec_oe [0:127];
  logic rec_do [0:127];
  int rises = 0;

  always @(posedge mdc_o) begin
    if (rises < 128) begin
      rec_oe[rises] = mdio_oe_o;
      rec_do[rises] = mdio_o;
    end
    rises++;
  end

  // PHY model: answers reads to PHY_AD, changes its output when MDC falls
  always @(negedge mdc_o) begin
    automatic int s = rises;
    automatic logic [4:0] pa, ra;
    automatic bit hit;
    mdio_i = 1'b1;
    if (s >= 46 && s < 128) begin
      for (int k = 0; k < 5; k++) begin
        pa[4-k] = rec_do[36+k];
        ra[4-k] = rec_do[41+k];
      end
      hit = rec_oe[34] && rec_do[34] && !rec_do[35] && (pa == PHY_AD);
      if (hit) begin
        if (s == 46)      mdio_i = 1'b0;
        else if (s <= 62) mdio_i = phy_word(ra)[62-s];
      end
    end
  end

  // half-period measurement while busy
  int hi_run = 0, lo_run = 0;
  int hi_min, hi_max, lo_min, lo_max;

  task automatic clear_runs();
    hi_min = 1000; hi_max = 0; lo_min = 1000; lo_max = 0;
  endtask

  always @(negedge clk) begin
    if (busy_o && mdc_o) begin
      hi_run++;
      if (lo_run > 0) begin
        if (lo_run < lo_min) lo_min = lo_run;
        if (lo_run > lo_max) lo_max = lo_run;
        lo_run = 0;
      end
    end else begin
      if (busy_o) lo_run++;
      if (hi_run > 0) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
        hi_run = 0;
      end
      if (!busy_o) lo_run = 0;
    end
  end

  typedef struct {
    bit          rd;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    int          half;
    bit          eerr;
    logic [15:0] edata;
    int          erises;
  } item_t;

  item_t sbq[$];
  logic [15:0] last_rd = '0;

  function automatic logic [1:0] exp_slot(item_t it, int s);
    automatic logic [13:0] hdr = {2'b01, (it.rd ? 2'b10 : 2'b01), it.phy, it.rg};
    if (s < 32) return 2'b11;
    if (s < 46) return {1'b1, hdr[13-(s-32)]};
    if (it.rd) return 2'b00;
    if (s == 46) return 2'b11;
    if (s == 47) return 2'b10;
    if (s < 64) return {1'b1, it.wd[15-(s-48)]};
    return 2'b00;
  endfunction

  // monitor: pops the scoreboard at each done strobe
  bit done_prev = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done_prev) chk(!done_o, "R9 done one clock", done_o, 0);
      if (done_o) begin
        if (sbq.size() == 0) begin
          chk(0, "R8 unexpected frame", 1, 0);
        end else begin
          automatic item_t it = sbq.pop_front();
          automatic int bad_pre = 0, bad_hdr = 0, bad_rest = 0;
          automatic int eh = (it.half == 0) ? 1 : it.half;
          for (int s = 0; s < it.erises && s < 128; s++) begin
            automatic logic [1:0] e = exp_slot(it, s);
            automatic bit ok = (rec_oe[s] == e[1]) && (!e[1] || rec_do[s] == e[0]);
            if (!ok) begin
              if (s < 32) bad_pre++;
              else if (s < 46) bad_hdr++;
              else bad_rest++;
            end
          end
          chk(bad_pre == 0, "R2 preamble slots", bad_pre, 0);
          chk(bad_hdr == 0, "R3 header bits", bad_hdr, 0);
          chk(bad_rest == 0, it.rd ? "R5 read release" : "R7 write turnaround/data", bad_rest, 0);
          chk(rises == it.erises,
              it.eerr ? "R6 recovery length" : (it.rd ? "R5 read length" : "R7 write length"),
              rises, it.erises);
          chk(err_o == it.eerr, "R6 error flag", err_o, it.eerr);
          chk(rd_data_o == it.edata, it.rd ? "R5 read data" : "R9 read data held", rd_data_o, it.edata);
          chk(hi_min == eh && hi_max == eh, "R4 high half length", hi_max, eh);
          chk(lo_min == eh && lo_max == eh, "R4 low half length", lo_max, eh);
          chk(!mdc_o && !mdio_oe_o && !busy_o, "R9 parked at done",
              {mdc_o, mdio_oe_o, busy_o}, 0);
        end
        mon_frames++;
      end
      done_prev = done_o;
    end
  end

  // driver: pushes the expected result, then launches the frame
  task automatic send(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd,
                      int half, bit poke);
    automatic item_t it;
    automatic int target = mon_frames + 1;
    while (busy_o) @(negedge clk);
    it.rd = rd; it.phy = phy; it.rg = rg; it.wd = wd; it.half = half;
    if (rd && phy == PHY_AD) begin
      it.eerr = 0; it.edata = phy_word(rg); it.erises = 65;
    end else if (rd) begin
      it.eerr = 1; it.edata = '0; it.erises = 79;
    end else begin
      it.eerr = 0; it.edata = last_rd; it.erises = 65;
    end
    last_rd = it.edata;
    sbq.push_back(it);
    rises = 0;
    mdio_i = 1'b1;
    clear_runs();
    req_read_i = rd; req_phy_i = phy; req_reg_i = rg; req_wdata_i = wd;
    half_cfg_i = HALF_W'(half);
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    chk(busy_o, "R8 busy after accept", busy_o, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      req_read_i = ~rd; req_phy_i = ~phy; req_reg_i = ~rg; req_wdata_i = ~wd;
      half_cfg_i = 8'd1;
      req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      chk(busy_o, "R8 busy during ignored request", busy_o, 1);
    end
    while (mon_frames < target) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o, "R8 no frame from ignored request", busy_o, 0);
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog expired", 0, 1);
    wrap_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1
    chk(!mdc_o, "R1 reset mdc", mdc_o, 0);
    chk(!mdio_oe_o, "R1 reset oe", mdio_oe_o, 0);
    chk(!busy_o && !done_o, "R1 reset busy/done", busy_o, 0);
    chk(!err_o, "R1 reset err", err_o, 0);
    rst = 1'b0;
    @(negedge clk);

    send(0, PHY_AD, 5'h11, 16'hBEEF, 1, 0);   // R7 write, half 1
    send(0, 5'h1C, 5'h02, 16'h4A35, 0, 0);    // R4 half 0 clamps to 1
    send(1, PHY_AD, 5'h05, 16'h0000, 2, 0);   // R5 good read
    send(1, 5'h1A, 5'h07, 16'h0000, 2, 0);    // R6 silent PHY
    send(1, PHY_AD, 5'h1F, 16'h0000, 3, 0);   // R5 error cleared
    send(0, PHY_AD, 5'h00, 16'h0001, 5, 1);   // R8 request while busy
    send(1, 5'h1A, 5'h13, 16'h0000, 4, 0);    // R6 again
    send(0, 5'h15, 5'h15, 16'h8000, 2, 0);    // R9 err cleared by write
    send(1, PHY_AD, 5'h0A, 16'h0000, 3, 1);   // R5 read with poke
    wrap_up();
  end
endmodule